// File: doc/BRIEF.md
# Dual-Port Mailbox Bus Interface

This block holds the control and decode logic for both sides of a bidirectional FIFO pair that also carries one mailbox register in each direction. Each side has its own clock and its own 36-bit tri-state data bus, plus four controls: chip select (active low), a direction select, an enable, and a mailbox select. On every rising edge of its clock, each side decides whether the edge performs one of four operations: a FIFO write, a FIFO read, a mailbox write or a mailbox read. It may also perform none of them. The FIFO storage sits outside the block. The block reaches it through push and pop strobes that are qualified by space-available and data-available flags supplied by that storage.

The two sides use opposite direction polarities. Side A drives its bus when its direction select is low. Side B drives its bus when its direction select is high. A word that a side reads, from its FIFO or from its incoming mailbox, lands in that side's output register, which then drives the bus.

Each mailbox carries an active-low full flag. A mail write from the sending side pulls the flag low. The flag crosses into the receiving side's clock domain through a two-stage synchronizer. A mail read on the receiving side releases the flag. While the sender still sees the mailbox as full, any further mail write is dropped.

Top module: `mbx_bus_if`

## Requirements
- R1: While a side's chip select is high, that side never drives its bus, and no push, pop, mail write or mail read comes from that side, whatever its other controls are.
- R2: Side A drives its bus with its output register when chip select is low and `a_wr_rd` is 0, and leaves the bus undriven when `a_wr_rd` is 1. After reset the output register holds 0.
- R3: Side B uses the opposite polarity: it drives its bus when chip select is low and `b_wr_rd` is 1, and leaves the bus undriven when `b_wr_rd` is 0.
- R4: With enable low, a side performs no operation, even if its bus is in output direction.
- R5: With chip select low, enable high, mailbox select 0 and input direction, the side asserts its FIFO push strobe for that edge, with the bus word on its write-data port, but only while its space flag is 1.
- R6: With chip select low, enable high, mailbox select 0 and output direction, the side asserts its FIFO pop strobe, but only while its data-available flag is 1. The read-data word then appears in the output register after that clock edge.
- R7: A mail write (mailbox select 1, input direction) stores the bus word in the outgoing mailbox. The receiving side's active-low full flag (`mb1_full_n` for A to B, `mb2_full_n` for B to A) then reads 0 within three receiving-side clock edges.
- R8: A mail read (mailbox select 1, output direction) loads the incoming mailbox word into the output register. If the mailbox was full, its full flag reads 1 right after that edge. A mail read on an empty mailbox leaves the flag at 1.
- R9: A mail write issued while the sending side still sees its mailbox as full is dropped, so the word held in the mailbox stays the first one.
- R10: Operations on the two sides proceed independently and may fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| clk_b | input | 1 | Side B clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each clock domain |
| a_cs_n | input | 1 | Side A chip select, active low |
| a_wr_rd | input | 1 | Side A direction: 1 input, 0 output |
| a_en | input | 1 | Side A operation enable |
| a_mb_sel | input | 1 | Side A selects mailbox path when 1 |
| a_bus | inout | 36 | Side A tri-state data bus |
| a_fifo_space | input | 1 | A-to-B FIFO has room |
| a_fifo_push | output | 1 | Push strobe into A-to-B FIFO |
| a_fifo_wdata | output | 36 | Word pushed into A-to-B FIFO |
| a_fifo_avail | input | 1 | B-to-A FIFO holds data |
| a_fifo_pop | output | 1 | Pop strobe from B-to-A FIFO |
| a_fifo_rdata | input | 36 | Head word of B-to-A FIFO |
| mb2_full_n | output | 1 | B-to-A mailbox full, active low, side A domain |
| b_cs_n | input | 1 | Side B chip select, active low |
| b_wr_rd | input | 1 | Side B direction: 1 output, 0 input |
| b_en | input | 1 | Side B operation enable |
| b_mb_sel | input | 1 | Side B selects mailbox path when 1 |
| b_bus | inout | 36 | Side B tri-state data bus |
| b_fifo_space | input | 1 | B-to-A FIFO has room |
| b_fifo_push | output | 1 | Push strobe into B-to-A FIFO |
| b_fifo_wdata | output | 36 | Word pushed into B-to-A FIFO |
| b_fifo_avail | input | 1 | A-to-B FIFO holds data |
| b_fifo_pop | output | 1 | Pop strobe from A-to-B FIFO |
| b_fifo_rdata | input | 36 | Head word of A-to-B FIFO |
| mb1_full_n | output | 1 | A-to-B mailbox full, active low, side B domain |

## Verification
Two activities on opposite sides can fall in the same cycle: a FIFO read on side A and a mail write on side B. The bench forks the two sides so that both operations land in overlapping clock periods. It then judges three things: that the popped word shows up on bus A, that no FIFO strobe leaks from the mail write, and that `mb2_full_n` falls afterwards and is released by a later mail read on A that returns B's word. Free-running random traffic on both sides at once gives further overlap between FIFO pushes, pops and idle cycles.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and the per-edge operation code of one bus side.
package mbx_pkg;
    localparam int unsigned BUS_W = 36;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_FIFO_WR = 3'd1,
        OP_FIFO_RD = 3'd2,
        OP_MAIL_WR = 3'd3,
        OP_MAIL_RD = 3'd4
    } op_e;
endpackage

// File: rtl/mbx_port_ctl.sv
`timescale 1ns/1ps
// Module: mbx_port_ctl
// Decodes one bus side's controls into a bus output enable and a single
// per-edge operation, and holds the side's output register.
// Assumes: strobes are combinational and consumed by the FIFO on the same
// rising edge; OUT_LEVEL is the direction-select level that means "output".
module mbx_port_ctl #(
    parameter int unsigned W         = 36,
    parameter bit          OUT_LEVEL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         wr_rd,
    input  logic         en,
    input  logic         mb_sel,
    input  logic         fifo_space,
    input  logic         fifo_avail,
    input  logic [W-1:0] fifo_rdata,
    input  logic [W-1:0] mail_in,
    output logic         oe,
    output logic [W-1:0] q,
    output logic         fifo_push,
    output logic         fifo_pop,
    output logic         mail_wr,
    output logic         mail_rd
);
    import mbx_pkg::*;

    logic out_dir;
    op_e  op;

    assign out_dir = (wr_rd == OUT_LEVEL);

    // Bus output enable follows chip select and direction only.
    assign oe = !cs_n && out_dir;

    // Pick the operation for this edge from the enable and path selects.
    always_comb begin
        op = OP_IDLE;
        if (!cs_n && en) begin
            if (mb_sel) begin
                op = out_dir ? OP_MAIL_RD : OP_MAIL_WR;
            end else if (out_dir) begin
                op = fifo_avail ? OP_FIFO_RD : OP_IDLE;
            end else begin
                op = fifo_space ? OP_FIFO_WR : OP_IDLE;
            end
        end
    end

    assign fifo_push = (op == OP_FIFO_WR);
    assign fifo_pop  = (op == OP_FIFO_RD);
    assign mail_wr   = (op == OP_MAIL_WR);
    assign mail_rd   = (op == OP_MAIL_RD);

    // Output register captures the word read on this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (fifo_pop) begin
            q <= fifo_rdata;
        end else if (mail_rd) begin
            q <= mail_in;
        end
    end

    // R1
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !(fifo_push || fifo_pop || mail_wr || mail_rd));

    // R4
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));

    // R5
    push_needs_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> fifo_space);

    // R6
    pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> fifo_avail);

    // R6
    pop_loads_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> (q == $past(fifo_rdata)));

    // R1
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_push, fifo_pop, mail_wr, mail_rd}));
endmodule

// File: rtl/mbx_mail_cdc.sv
`timescale 1ns/1ps
// Module: mbx_mail_cdc
// One-direction mailbox: a word register written in the sender's domain and a
// full state kept as a toggle pair, each toggle synchronized into the other
// domain through SYNC_STAGES flops.
// Assumes: the word register is stable while full, so the reader may sample
// it directly once its synchronized view says full.
module mbx_mail_cdc #(
    parameter int unsigned W           = 36,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk_w,
    input  logic         clk_r,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         full_n
);
    logic                   wr_tgl;
    logic                   rd_tgl;
    logic [SYNC_STAGES-1:0] rd_sync;
    logic [SYNC_STAGES-1:0] wr_sync;
    logic [W-1:0]           mail_q;
    logic                   full_w;
    logic                   full_r;

    assign full_w = wr_tgl ^ rd_sync[SYNC_STAGES-1];
    assign full_r = wr_sync[SYNC_STAGES-1] ^ rd_tgl;
    assign full_n = !full_r;
    assign rdata  = mail_q;

    // Sender side: accept a word only while the mailbox looks empty.
    always_ff @(posedge clk_w) begin
        if (!rst_n) begin
            wr_tgl <= 1'b0;
            mail_q <= '0;
        end else if (wr && !full_w) begin
            wr_tgl <= !wr_tgl;
            mail_q <= wdata;
        end
    end

    // Sender side: bring the reader's toggle across.
    always_ff @(posedge clk_w) begin
        if (!rst_n) begin
            rd_sync <= '0;
        end else begin
            rd_sync <= {rd_sync[SYNC_STAGES-2:0], rd_tgl};
        end
    end

    // Reader side: bring the sender's toggle across.
    always_ff @(posedge clk_r) begin
        if (!rst_n) begin
            wr_sync <= '0;
        end else begin
            wr_sync <= {wr_sync[SYNC_STAGES-2:0], wr_tgl};
        end
    end

    // Reader side: a read of a full mailbox releases it.
    always_ff @(posedge clk_r) begin
        if (!rst_n) begin
            rd_tgl <= 1'b0;
        end else if (rd && full_r) begin
            rd_tgl <= !rd_tgl;
        end
    end

    // R9
    full_write_drop_chk: assert property (@(posedge clk_w) disable iff (!rst_n)
        (wr && full_w) |=> $stable(mail_q));

    // R8
    read_release_chk: assert property (@(posedge clk_r) disable iff (!rst_n)
        (rd && full_r) |=> full_n);

    // R7
    write_marks_full_chk: assert property (@(posedge clk_w) disable iff (!rst_n)
        (wr && !full_w) |=> full_w);
endmodule

// File: rtl/mbx_bus_if.sv
`timescale 1ns/1ps
// Module: mbx_bus_if
// Top of the two-sided bus interface: one decode/output block per side, one
// mailbox per direction, and the tri-state drivers of both buses.
// Assumes: clk_a and clk_b may be unrelated; rst_n is held long enough to be
// seen on several edges of both clocks.
module mbx_bus_if #(
    parameter int unsigned W           = mbx_pkg::BUS_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst_n,
    input  logic         a_cs_n,
    input  logic         a_wr_rd,
    input  logic         a_en,
    input  logic         a_mb_sel,
    inout  wire  [W-1:0] a_bus,
    input  logic         a_fifo_space,
    output logic         a_fifo_push,
    output logic [W-1:0] a_fifo_wdata,
    input  logic         a_fifo_avail,
    output logic         a_fifo_pop,
    input  logic [W-1:0] a_fifo_rdata,
    output logic         mb2_full_n,
    input  logic         b_cs_n,
    input  logic         b_wr_rd,
    input  logic         b_en,
    input  logic         b_mb_sel,
    inout  wire  [W-1:0] b_bus,
    input  logic         b_fifo_space,
    output logic         b_fifo_push,
    output logic [W-1:0] b_fifo_wdata,
    input  logic         b_fifo_avail,
    output logic         b_fifo_pop,
    input  logic [W-1:0] b_fifo_rdata,
    output logic         mb1_full_n
);
    logic         a_oe, b_oe;
    logic [W-1:0] a_q, b_q;
    logic         a_mail_wr, a_mail_rd, b_mail_wr, b_mail_rd;
    logic [W-1:0] mail1_word, mail2_word;

    mbx_port_ctl #(.W(W), .OUT_LEVEL(1'b0)) side_a_i (
        .clk(clk_a), .rst_n(rst_n), .cs_n(a_cs_n), .wr_rd(a_wr_rd),
        .en(a_en), .mb_sel(a_mb_sel), .fifo_space(a_fifo_space),
        .fifo_avail(a_fifo_avail), .fifo_rdata(a_fifo_rdata),
        .mail_in(mail2_word), .oe(a_oe), .q(a_q), .fifo_push(a_fifo_push),
        .fifo_pop(a_fifo_pop), .mail_wr(a_mail_wr), .mail_rd(a_mail_rd)
    );

    mbx_port_ctl #(.W(W), .OUT_LEVEL(1'b1)) side_b_i (
        .clk(clk_b), .rst_n(rst_n), .cs_n(b_cs_n), .wr_rd(b_wr_rd),
        .en(b_en), .mb_sel(b_mb_sel), .fifo_space(b_fifo_space),
        .fifo_avail(b_fifo_avail), .fifo_rdata(b_fifo_rdata),
        .mail_in(mail1_word), .oe(b_oe), .q(b_q), .fifo_push(b_fifo_push),
        .fifo_pop(b_fifo_pop), .mail_wr(b_mail_wr), .mail_rd(b_mail_rd)
    );

    mbx_mail_cdc #(.W(W), .SYNC_STAGES(SYNC_STAGES)) mail_ab_i (
        .clk_w(clk_a), .clk_r(clk_b), .rst_n(rst_n), .wr(a_mail_wr),
        .wdata(a_bus), .rd(b_mail_rd), .rdata(mail1_word), .full_n(mb1_full_n)
    );

    mbx_mail_cdc #(.W(W), .SYNC_STAGES(SYNC_STAGES)) mail_ba_i (
        .clk_w(clk_b), .clk_r(clk_a), .rst_n(rst_n), .wr(b_mail_wr),
        .wdata(b_bus), .rd(a_mail_rd), .rdata(mail2_word), .full_n(mb2_full_n)
    );

    // Tri-state drivers and FIFO write data taken straight from the buses.
    assign a_bus        = a_oe ? a_q : {W{1'bz}};
    assign b_bus        = b_oe ? b_q : {W{1'bz}};
    assign a_fifo_wdata = a_bus;
    assign b_fifo_wdata = b_bus;

    // R3
    b_input_dir_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!b_wr_rd || b_cs_n) |-> !b_oe);

    // R2
    a_input_dir_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        (a_wr_rd || a_cs_n) |-> !a_oe);
endmodule

// File: tb/mbx_bus_if_tb_top.sv
`timescale 1ns/1ps
module mbx_bus_if_tb_top;
    logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
    always #2.5 clk_a = ~clk_a;
    initial begin
        #1;
        forever #2.5 clk_b = ~clk_b;
    end

    logic a_cs_n = 1'b1, a_wr_rd = 1'b1, a_en = 1'b0, a_mb_sel = 1'b0;
    logic b_cs_n = 1'b1, b_wr_rd = 1'b0, b_en = 1'b0, b_mb_sel = 1'b0;
    logic a_fifo_space = 1'b0, a_fifo_avail = 1'b0;
    logic b_fifo_space = 1'b0, b_fifo_avail = 1'b0;
    logic [35:0] a_fifo_rdata = '0, b_fifo_rdata = '0;
    logic a_fifo_push, a_fifo_pop, b_fifo_push, b_fifo_pop;
    logic [35:0] a_fifo_wdata, b_fifo_wdata;
    logic mb1_full_n, mb2_full_n;
    logic a_drv = 1'b1, b_drv = 1'b1;
    logic [35:0] a_val = '0, b_val = '0;
    logic [35:0] exp_qa = '0, exp_qb = '0;
    wire  [35:0] a_bus, b_bus;
    assign a_bus = a_drv ? a_val : {36{1'bz}};
    assign b_bus = b_drv ? b_val : {36{1'bz}};

    int total = 0, bad = 0;
    bit done = 1'b0;

    mbx_bus_if dut_i (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_cs_n(a_cs_n), .a_wr_rd(a_wr_rd), .a_en(a_en), .a_mb_sel(a_mb_sel),
        .a_bus(a_bus), .a_fifo_space(a_fifo_space), .a_fifo_push(a_fifo_push),
        .a_fifo_wdata(a_fifo_wdata), .a_fifo_avail(a_fifo_avail),
        .a_fifo_pop(a_fifo_pop), .a_fifo_rdata(a_fifo_rdata), .mb2_full_n(mb2_full_n),
        .b_cs_n(b_cs_n), .b_wr_rd(b_wr_rd), .b_en(b_en), .b_mb_sel(b_mb_sel),
        .b_bus(b_bus), .b_fifo_space(b_fifo_space), .b_fifo_push(b_fifo_push),
        .b_fifo_wdata(b_fifo_wdata), .b_fifo_avail(b_fifo_avail),
        .b_fifo_pop(b_fifo_pop), .b_fifo_rdata(b_fifo_rdata), .mb1_full_n(mb1_full_n)
    );

    task automatic chk(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected {push, pop} from the decode requirements.
    function automatic logic [1:0] exp_strobes(input bit cs_n, input bit out_dir,
                                               input bit en, input bit space,
                                               input bit avail);
        if (cs_n || !en) return 2'b00;
        if (out_dir) return {1'b0, avail};
        return {space, 1'b0};
    endfunction

    function automatic logic [35:0] rnd36();
        return {$urandom_range(15, 0), $urandom()};
    endfunction

    function automatic string tag(input bit cs_n, input bit en, input string base);
        if (cs_n) return "R1";
        if (!en) return "R4";
        return base;
    endfunction

    task automatic rand_a(input int n);
        void'($urandom(32'h00c0ffee));
        for (int i = 0; i < n; i++) begin
            logic [1:0] e;
            bit od;
            @(negedge clk_a);
            a_cs_n = ($urandom_range(3, 0) == 0);
            a_wr_rd = $urandom_range(1, 0);
            a_en = $urandom_range(1, 0);
            a_mb_sel = 1'b0;
            a_fifo_space = $urandom_range(1, 0);
            a_fifo_avail = $urandom_range(1, 0);
            a_fifo_rdata = rnd36();
            od = !a_wr_rd;
            a_val = rnd36();
            a_drv = a_cs_n || !od;
            #1;
            if (!a_cs_n && od) chk(a_bus == exp_qa, "R2 R6 bus A", a_bus, exp_qa);
            else chk(a_bus == a_val, a_cs_n ? "R1 bus A" : "R2 bus A", a_bus, a_val);
            e = exp_strobes(a_cs_n, od, a_en, a_fifo_space, a_fifo_avail);
            chk(a_fifo_push == e[1], tag(a_cs_n, a_en, "R5 push A"), 36'(a_fifo_push), 36'(e[1]));
            chk(a_fifo_pop == e[0], tag(a_cs_n, a_en, "R6 pop A"), 36'(a_fifo_pop), 36'(e[0]));
            if (e[1]) chk(a_fifo_wdata == a_val, "R5 wdata A", a_fifo_wdata, a_val);
            @(posedge clk_a);
            if (e[0]) exp_qa = a_fifo_rdata;
        end
        @(negedge clk_a);
        a_cs_n = 1'b1; a_en = 1'b0; a_drv = 1'b1;
    endtask

    task automatic rand_b(input int n);
        void'($urandom(32'h0badcafe));
        for (int i = 0; i < n; i++) begin
            logic [1:0] e;
            bit od;
            @(negedge clk_b);
            b_cs_n = ($urandom_range(3, 0) == 0);
            b_wr_rd = $urandom_range(1, 0);
            b_en = $urandom_range(1, 0);
            b_mb_sel = 1'b0;
            b_fifo_space = $urandom_range(1, 0);
            b_fifo_avail = $urandom_range(1, 0);
            b_fifo_rdata = rnd36();
            od = b_wr_rd;
            b_val = rnd36();
            b_drv = b_cs_n || !od;
            #1;
            if (!b_cs_n && od) chk(b_bus == exp_qb, "R3 R6 bus B", b_bus, exp_qb);
            else chk(b_bus == b_val, b_cs_n ? "R1 bus B" : "R3 bus B", b_bus, b_val);
            e = exp_strobes(b_cs_n, od, b_en, b_fifo_space, b_fifo_avail);
            chk(b_fifo_push == e[1], tag(b_cs_n, b_en, "R5 push B"), 36'(b_fifo_push), 36'(e[1]));
            chk(b_fifo_pop == e[0], tag(b_cs_n, b_en, "R6 pop B"), 36'(b_fifo_pop), 36'(e[0]));
            if (e[1]) chk(b_fifo_wdata == b_val, "R5 wdata B", b_fifo_wdata, b_val);
            @(posedge clk_b);
            if (e[0]) exp_qb = b_fifo_rdata;
        end
        @(negedge clk_b);
        b_cs_n = 1'b1; b_en = 1'b0; b_drv = 1'b1;
    endtask

    // One mail write from side A with word w.
    task automatic a_mail_write(input logic [35:0] w);
        @(negedge clk_a);
        a_cs_n = 1'b0; a_wr_rd = 1'b1; a_en = 1'b1; a_mb_sel = 1'b1;
        a_drv = 1'b1; a_val = w;
        #1;
        chk(a_fifo_push == 1'b0, "R7 no push on mail write", 36'(a_fifo_push), 36'd0);
        @(posedge clk_a);
    endtask

    // One mail read on side B; checks flag release and the word on the bus.
    task automatic b_mail_read(input logic [35:0] w, input string req);
        @(negedge clk_b);
        b_cs_n = 1'b0; b_wr_rd = 1'b1; b_en = 1'b1; b_mb_sel = 1'b1; b_drv = 1'b0;
        #1;
        chk(b_fifo_pop == 1'b0, "R8 no pop on mail read", 36'(b_fifo_pop), 36'd0);
        @(posedge clk_b);
        #1;
        chk(mb1_full_n == 1'b1, "R8 flag released", 36'(mb1_full_n), 36'd1);
        @(negedge clk_b);
        b_en = 1'b0;
        #1;
        chk(b_bus == w, req, b_bus, w);
        exp_qb = w;
    endtask

    initial begin
        repeat (4) @(posedge clk_a);
        @(negedge clk_a);
        rst_n = 1'b1;
        // Reset state: flags released, output registers zero.
        @(negedge clk_a);
        a_cs_n = 1'b0; a_wr_rd = 1'b0; a_en = 1'b0; a_drv = 1'b0;
        b_cs_n = 1'b0; b_wr_rd = 1'b1; b_en = 1'b0; b_drv = 1'b0;
        #1;
        chk(a_bus == '0, "R2 reset bus A", a_bus, '0);
        chk(b_bus == '0, "R3 reset bus B", b_bus, '0);
        chk(mb1_full_n == 1'b1, "R7 reset flag 1", 36'(mb1_full_n), 36'd1);
        chk(mb2_full_n == 1'b1, "R7 reset flag 2", 36'(mb2_full_n), 36'd1);
        a_cs_n = 1'b1; a_drv = 1'b1; b_cs_n = 1'b1; b_drv = 1'b1;

        // Mailbox A to B: write, write again while full, then read.
        a_mail_write(36'h1_2345_6789);
        a_mail_write(36'h9_8765_4321);
        @(negedge clk_a);
        a_en = 1'b0; a_cs_n = 1'b1;
        repeat (4) @(negedge clk_b);
        chk(mb1_full_n == 1'b0, "R7 flag set after write", 36'(mb1_full_n), 36'd0);
        b_mail_read(36'h1_2345_6789, "R9 second write dropped");
        // Read on an empty mailbox keeps the flag released and the word.
        b_mail_read(36'h1_2345_6789, "R8 empty read keeps word");
        b_cs_n = 1'b1; b_drv = 1'b1;
        // After the release reaches side A, a new write is accepted.
        repeat (5) @(negedge clk_a);
        a_mail_write(36'h0_aaaa_5555);
        @(negedge clk_a);
        a_en = 1'b0; a_cs_n = 1'b1;
        repeat (4) @(negedge clk_b);
        chk(mb1_full_n == 1'b0, "R7 flag set on new write", 36'(mb1_full_n), 36'd0);
        b_mail_read(36'h0_aaaa_5555, "R7 new word delivered");
        b_cs_n = 1'b1; b_drv = 1'b1;

        // Same-cycle activity: FIFO read on A while B writes mailbox 2.
        fork
            begin
                @(negedge clk_a);
                a_cs_n = 1'b0; a_wr_rd = 1'b0; a_en = 1'b1; a_mb_sel = 1'b0;
                a_fifo_avail = 1'b1; a_fifo_rdata = 36'h3_c3c3_c3c3; a_drv = 1'b0;
                #1;
                chk(a_fifo_pop == 1'b1, "R10 pop A during B mail write", 36'(a_fifo_pop), 36'd1);
                @(posedge clk_a);
                exp_qa = 36'h3_c3c3_c3c3;
                @(negedge clk_a);
                a_en = 1'b0;
                #1;
                chk(a_bus == exp_qa, "R6 popped word on bus A", a_bus, exp_qa);
            end
            begin
                @(negedge clk_b);
                b_cs_n = 1'b0; b_wr_rd = 1'b0; b_en = 1'b1; b_mb_sel = 1'b1;
                b_drv = 1'b1; b_val = 36'h5_0f0f_0f0f;
                #1;
                chk(b_fifo_push == 1'b0, "R10 no push on B mail write", 36'(b_fifo_push), 36'd0);
                @(posedge clk_b);
                @(negedge clk_b);
                b_en = 1'b0; b_cs_n = 1'b1;
            end
        join
        repeat (4) @(negedge clk_a);
        chk(mb2_full_n == 1'b0, "R7 flag 2 set", 36'(mb2_full_n), 36'd0);
        @(negedge clk_a);
        a_cs_n = 1'b0; a_wr_rd = 1'b0; a_en = 1'b1; a_mb_sel = 1'b1; a_drv = 1'b0;
        @(posedge clk_a);
        #1;
        chk(mb2_full_n == 1'b1, "R8 flag 2 released", 36'(mb2_full_n), 36'd1);
        @(negedge clk_a);
        a_en = 1'b0;
        #1;
        chk(a_bus == 36'h5_0f0f_0f0f, "R8 mail word on bus A", a_bus, 36'h5_0f0f_0f0f);
        exp_qa = 36'h5_0f0f_0f0f;
        a_cs_n = 1'b1; a_drv = 1'b1;

        // Random traffic on both sides at once (R10).
        fork
            rand_a(400);
            rand_b(400);
        join
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_a);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule